// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block holds the electrical settings for one port of eight pads and drives them as static control vectors to the pad ring. Software writes byte-wide values to word offsets on a simple single-port register bus. Each bit position controls only the pin of the same index. The bank covers open-drain enable, weak pull-up, weak pull-down, three drive-strength selects (2, 4 and 8 mA) and a slew-limit bit.

Some registers exclude each other. The bank keeps them consistent in hardware, so software never has to clear a sibling register itself. Each pin carries two small per-pin state machines.

The pull machine has the states PULL_NONE, PULL_UP and PULL_DOWN, and these transitions:
- GO_UP: a 1 in the pull-up register, from any state.
- GO_DOWN: a 1 in the pull-down register, from any state.
- DROP_UP: a 0 written to the pull-up register while in PULL_UP returns the pin to PULL_NONE.
- DROP_DOWN: a 0 written to the pull-down register while in PULL_DOWN returns the pin to PULL_NONE.

The drive machine has the states DRV_2MA, DRV_4MA and DRV_8MA. Its transitions are SEL_2, SEL_4 and SEL_8, each taken on a 1 in the matching drive register from any state. A 0 causes no transition.

The open-drain bit is combined with a per-pin direction input. The result tells the pad whether the pin is an open-drain driver or an open-drain receiver.

Top module: `gpad_cfg_bank`

## Requirements
- R1: After reset every pin selects 2 mA drive. Pull-up, pull-down, open-drain and slew are all 0 on the outputs and on readback.
- R2: A write to offset 1 (pull-up) with a 1 in bit i enables pull-up on pin i and clears its pull-down. A 0 in bit i clears pin i's pull-up and leaves its pull-down unchanged.
- R3: A write to offset 2 (pull-down) with a 1 in bit i enables pull-down on pin i and clears its pull-up. A 0 in bit i clears pin i's pull-down and leaves its pull-up unchanged.
- R4: A write to offset 3, 4 or 5 (2, 4 or 8 mA) with a 1 in bit i selects that strength on pin i and clears the other two. A 0 bit has no effect, so exactly one strength is selected per pin at all times.
- R5: Offset 6 holds the slew bits and reads back as written. pad_slew[i] is the slew bit ANDed with pin i's 8 mA select.
- R6: Offset 0 holds open-drain enables. pad_od_drive[i] = od[i] & pin_dir[i] and pad_od_sense[i] = od[i] & ~pin_dir[i], with no clock delay from pin_dir.
- R7: Bit i of any write affects only pin i. Other pins keep their settings.
- R8: rdata combinationally returns the register at addr (offsets 0..6 as above, drive offsets returning the per-pin selects). Offset 7 reads 0 and a write to it changes nothing.
- R9: A write takes effect on the clock edge where wr_en is 1, visible on outputs after that edge. With wr_en at 0, addr and wdata change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 3 | Register word offset |
| wdata | input | 8 | Write data, one bit per pin |
| rdata | output | 8 | Read data for addr |
| pin_dir | input | 8 | Per-pin direction from the data path (1 = output) |
| pad_od_drive | output | 8 | Pin is an open-drain output |
| pad_od_sense | output | 8 | Pin is an open-drain input |
| pad_pu | output | 8 | Weak pull-up enable |
| pad_pd | output | 8 | Weak pull-down enable |
| pad_drv2 | output | 8 | 2 mA drive select |
| pad_drv4 | output | 8 | 4 mA drive select |
| pad_drv8 | output | 8 | 8 mA drive select |
| pad_slew | output | 8 | Effective slew-limit enable |

## Verification
A corrupted per-pin state machine shows at the ports on the next falling clock edge after the write that caused it. It can appear as both pulls active, or as zero or two drive selects on a pin. It can also appear as readback that disagrees with the pad vectors. A write that leaks to a neighbouring pin shows as a changed bit outside the written mask in the same cycle. Slew gating errors appear as soon as a pin leaves 8 mA with its slew bit set. Every write is followed by a full readback and a pad-vector comparison against a bench model, so a wrong state is caught within one write.

// File: rtl/gpad_pkg.sv
package gpad_pkg;
    localparam int unsigned OFF_OD   = 0;
    localparam int unsigned OFF_PU   = 1;
    localparam int unsigned OFF_PD   = 2;
    localparam int unsigned OFF_D2   = 3;
    localparam int unsigned OFF_D4   = 4;
    localparam int unsigned OFF_D8   = 5;
    localparam int unsigned OFF_SLEW = 6;
    localparam int unsigned NUM_REGS = 7;

    typedef enum logic [1:0] {
        PULL_NONE = 2'd0,
        PULL_UP   = 2'd1,
        PULL_DOWN = 2'd2
    } pull_e;

    typedef enum logic [1:0] {
        DRV_2MA = 2'd0,
        DRV_4MA = 2'd1,
        DRV_8MA = 2'd2
    } drive_e;
endpackage

// File: rtl/gpad_wdec.sv
module gpad_wdec #(
    parameter int unsigned ADDR_W = 3,
    localparam int unsigned SLOTS = 1 << ADDR_W
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [SLOTS-1:0]  wr_stb
);
    // One strobe per word offset; at most one is high per cycle.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign wr_stb[s] = wr_en && (addr == ADDR_W'(s));
    end
endmodule

// File: rtl/gpad_pull_bank.sv
module gpad_pull_bank
    import gpad_pkg::*;
#(
    parameter int unsigned PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_up,
    input  logic            wr_dn,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] pu,
    output logic [PINS-1:0] pd
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        pull_e state_q, state_d;

        // State register.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_q <= PULL_NONE;
            else        state_q <= state_d;
        end

        // Transitions: GO_UP, GO_DOWN, DROP_UP, DROP_DOWN.
        always_comb begin
            state_d = state_q;
            if (wr_up) begin
                if (wdata[p])                  state_d = PULL_UP;
                else if (state_q == PULL_UP)   state_d = PULL_NONE;
            end else if (wr_dn) begin
                if (wdata[p])                  state_d = PULL_DOWN;
                else if (state_q == PULL_DOWN) state_d = PULL_NONE;
            end
        end

        // Outputs.
        always_comb begin
            pu[p] = 1'b0;
            pd[p] = 1'b0;
            unique case (state_q)
                PULL_NONE: ;
                PULL_UP:   pu[p] = 1'b1;
                PULL_DOWN: pd[p] = 1'b1;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpad_drive_bank.sv
module gpad_drive_bank
    import gpad_pkg::*;
#(
    parameter int unsigned PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_d2,
    input  logic            wr_d4,
    input  logic            wr_d8,
    input  logic            wr_slew,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] drv2,
    output logic [PINS-1:0] drv4,
    output logic [PINS-1:0] drv8,
    output logic [PINS-1:0] slew_raw,
    output logic [PINS-1:0] slew_eff
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       slew_raw <= '0;
        else if (wr_slew) slew_raw <= wdata;
    end

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        drive_e state_q, state_d;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_q <= DRV_2MA;
            else        state_d_apply: state_q <= state_d;
        end

        // Transitions SEL_2, SEL_4, SEL_8; a 0 bit leaves the state alone.
        always_comb begin
            state_d = state_q;
            if (wdata[p]) begin
                if (wr_d2)      state_d = DRV_2MA;
                else if (wr_d4) state_d = DRV_4MA;
                else if (wr_d8) state_d = DRV_8MA;
            end
        end

        always_comb begin
            drv2[p] = 1'b0;
            drv4[p] = 1'b0;
            drv8[p] = 1'b0;
            unique case (state_q)
                DRV_2MA: drv2[p] = 1'b1;
                DRV_4MA: drv4[p] = 1'b1;
                DRV_8MA: drv8[p] = 1'b1;
                default: drv2[p] = 1'b1;
            endcase
        end

        assign slew_eff[p] = slew_raw[p] & drv8[p];
    end
endmodule

// File: rtl/gpad_cfg_bank.sv
module gpad_cfg_bank
    import gpad_pkg::*;
#(
    parameter int unsigned PINS   = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PINS-1:0]   wdata,
    output logic [PINS-1:0]   rdata,
    input  logic [PINS-1:0]   pin_dir,
    output logic [PINS-1:0]   pad_od_drive,
    output logic [PINS-1:0]   pad_od_sense,
    output logic [PINS-1:0]   pad_pu,
    output logic [PINS-1:0]   pad_pd,
    output logic [PINS-1:0]   pad_drv2,
    output logic [PINS-1:0]   pad_drv4,
    output logic [PINS-1:0]   pad_drv8,
    output logic [PINS-1:0]   pad_slew
);
    localparam int unsigned SLOTS = 1 << ADDR_W;

    logic [SLOTS-1:0] wr_stb;
    logic [PINS-1:0]  od_q;
    logic [PINS-1:0]  slew_raw;

    gpad_wdec #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_stb (wr_stb)
    );

    gpad_pull_bank #(.PINS(PINS)) u_pull (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_up (wr_stb[OFF_PU]),
        .wr_dn (wr_stb[OFF_PD]),
        .wdata (wdata),
        .pu    (pad_pu),
        .pd    (pad_pd)
    );

    gpad_drive_bank #(.PINS(PINS)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_d2    (wr_stb[OFF_D2]),
        .wr_d4    (wr_stb[OFF_D4]),
        .wr_d8    (wr_stb[OFF_D8]),
        .wr_slew  (wr_stb[OFF_SLEW]),
        .wdata    (wdata),
        .drv2     (pad_drv2),
        .drv4     (pad_drv4),
        .drv8     (pad_drv8),
        .slew_raw (slew_raw),
        .slew_eff (pad_slew)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              od_q <= '0;
        else if (wr_stb[OFF_OD]) od_q <= wdata;
    end

    assign pad_od_drive = od_q & pin_dir;
    assign pad_od_sense = od_q & ~pin_dir;

    always_comb begin
        rdata = '0;
        case (int'(addr))
            OFF_OD:   rdata = od_q;
            OFF_PU:   rdata = pad_pu;
            OFF_PD:   rdata = pad_pd;
            OFF_D2:   rdata = pad_drv2;
            OFF_D4:   rdata = pad_drv4;
            OFF_D8:   rdata = pad_drv8;
            OFF_SLEW: rdata = slew_raw;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpad_bank_chk.sv
module gpad_bank_chk #(
    parameter int unsigned PINS   = 8,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [PINS-1:0]   wdata,
    input logic [PINS-1:0]   pad_pu,
    input logic [PINS-1:0]   pad_pd,
    input logic [PINS-1:0]   pad_drv2,
    input logic [PINS-1:0]   pad_drv4,
    input logic [PINS-1:0]   pad_drv8,
    input logic [PINS-1:0]   pad_slew
);
    a_r1_reset_values: assert property (@(posedge clk)
        !rst_n |=> (pad_drv2 == '1 && pad_drv4 == '0 && pad_drv8 == '0 &&
                    pad_pu == '0 && pad_pd == '0));

    a_r2_pulls_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);

    a_r2_up_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(1)) |=> ((pad_pu & $past(wdata)) == $past(wdata)));

    a_r3_down_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(2)) |=> ((pad_pd & $past(wdata)) == $past(wdata)));

    a_r4_one_strength: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_drv2 & pad_drv4) | (pad_drv2 & pad_drv8) | (pad_drv4 & pad_drv8)) == '0 &&
        (pad_drv2 | pad_drv4 | pad_drv8) == '1);

    a_r4_zero_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(4)) |=>
        ((pad_drv4 & ~$past(wdata)) == ($past(pad_drv4) & ~$past(wdata))));

    a_r5_slew_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_slew & ~pad_drv8) == '0);

    a_r7_other_pins_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(1)) |=>
        ((pad_pd & ~$past(wdata)) == ($past(pad_pd) & ~$past(wdata))));

    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pad_pu) && $stable(pad_pd) && $stable(pad_drv8)));
endmodule

bind gpad_cfg_bank gpad_bank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .pad_pu   (pad_pu),
    .pad_pd   (pad_pd),
    .pad_drv2 (pad_drv2),
    .pad_drv4 (pad_drv4),
    .pad_drv8 (pad_drv8),
    .pad_slew (pad_slew)
);

// File: tb/gpad_cfg_bank_test.sv
module gpad_cfg_bank_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] pin_dir = '0;
    logic [7:0] rdata, pad_od_drive, pad_od_sense, pad_pu, pad_pd;
    logic [7:0] pad_drv2, pad_drv4, pad_drv8, pad_slew;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] m_od, m_pu, m_pd, m_d2, m_d4, m_d8, m_sl;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpad_cfg_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_dir(pin_dir), .pad_od_drive(pad_od_drive),
        .pad_od_sense(pad_od_sense), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_drv2(pad_drv2), .pad_drv4(pad_drv4), .pad_drv8(pad_drv8),
        .pad_slew(pad_slew)
    );

    function automatic logic [7:0] exp_read(input int a);
        case (a)
            0: return m_od;
            1: return m_pu;
            2: return m_pd;
            3: return m_d2;
            4: return m_d4;
            5: return m_d8;
            6: return m_sl;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_od = '0; m_pu = '0; m_pd = '0;
        m_d2 = '1; m_d4 = '0; m_d8 = '0; m_sl = '0;
    endtask

    task automatic model_write(input int a, input logic [7:0] d);
        case (a)
            0: m_od = d;
            1: begin m_pu = d; m_pd = m_pd & ~d; end
            2: begin m_pd = d; m_pu = m_pu & ~d; end
            3: begin m_d2 |= d; m_d4 &= ~d; m_d8 &= ~d; end
            4: begin m_d4 |= d; m_d2 &= ~d; m_d8 &= ~d; end
            5: begin m_d8 |= d; m_d2 &= ~d; m_d4 &= ~d; end
            6: m_sl = d;
            default: ;
        endcase
    endtask

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(pad_pu == m_pu, req, pad_pu, m_pu);
        check(pad_pd == m_pd, req, pad_pd, m_pd);
        check(pad_drv2 == m_d2, req, pad_drv2, m_d2);
        check(pad_drv4 == m_d4, req, pad_drv4, m_d4);
        check(pad_drv8 == m_d8, req, pad_drv8, m_d8);
        check(pad_slew == (m_sl & m_d8), "R5", pad_slew, m_sl & m_d8);
        check(pad_od_drive == (m_od & pin_dir), "R6", pad_od_drive, m_od & pin_dir);
        check(pad_od_sense == (m_od & ~pin_dir), "R6", pad_od_sense, m_od & ~pin_dir);
        for (int a = 0; a < 8; a++) begin
            addr = 3'(a);
            #1;
            check(rdata == exp_read(a), "R8", rdata, exp_read(a));
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2 / R3: pull exclusivity and zero-bit clearing
        do_write(1, 8'hFF); check_all("R2");
        do_write(2, 8'h0F); check_all("R3");
        check(pad_pu == 8'hF0, "R3", pad_pu, 8'hF0);
        do_write(1, 8'h30); check_all("R2");
        check(pad_pd == 8'h0F, "R2", pad_pd, 8'h0F);

        // R4: drive selects
        do_write(5, 8'hAA); do_write(4, 8'h0F); check_all("R4");
        check(pad_drv2 == 8'h50, "R4", pad_drv2, 8'h50);
        do_write(3, 8'h00); check_all("R4");
        check(pad_drv8 == 8'hA0, "R4", pad_drv8, 8'hA0);

        // R5: slew gated by 8 mA
        do_write(6, 8'hFF); check_all("R5");
        check(pad_slew == 8'hA0, "R5", pad_slew, 8'hA0);

        // R6: open-drain with direction
        do_write(0, 8'hC3);
        pin_dir = 8'h81; #1; check_all("R6");
        pin_dir = 8'h7E; #1; check_all("R6");

        // R8: offset 7 write ignored
        do_write(7, 8'hFF); check_all("R8");

        // R9: bus activity without wr_en
        @(negedge clk);
        addr = 3'd1; wdata = 8'h00;
        @(negedge clk);
        addr = 3'd5; wdata = 8'hFF;
        @(negedge clk);
        check_all("R9");

        // R7: random writes against the model
        for (int i = 0; i < 300; i++) begin
            do_write(int'($urandom_range(0, 7)), 8'($urandom));
            pin_dir = 8'($urandom);
            #1;
            check_all("R7");
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule